// File: doc/BRIEF.md
# Thread Interrupt Priority Presenter

This block presents interrupts to a single hardware thread. It holds four independent exception contexts: hypervisor, operating system, user-level branch, and doorbell. Each context has a one-hot-per-priority pending bitmap, a registered most-favored pending priority, a current priority threshold and a notification status byte. When the router sends a notification, it names a context and a priority, and the matching pending bit is set. The exception line of a context is raised when its most-favored pending priority is numerically below its threshold. A lower number means a more favored priority.

Software reaches the registers through a small address window split into four pages. Page 0 is the physical view and reaches any context through a context field in the address. Pages 1, 2 and 3 are fixed to the hypervisor, OS and user contexts. A read of the acknowledge register does three things: it returns the status and the pending priority, it retires that pending bit, and it moves the threshold to the acknowledged level. A write to the threshold register re-evaluates the line at once.

Top module: `tip_presenter`

## Requirements
- R1: After reset every context has an empty pending bitmap, pending priority 0xFF, threshold 0x00 and status 0x00, and all four exception lines are low.
- R2: A notification with valid high sets bit `ntf_prio` of the pending bitmap of context `ntf_ctx` (0 hypervisor, 1 OS, 2 user, 3 doorbell) at the next clock edge. It leaves the other contexts unchanged.
- R3: The pending priority of a context equals the index of the lowest set bit of its pending bitmap, or 0xFF when the bitmap is empty. It is readable in bits [7:0] of the status register (select 2), with the bitmap in bits [31:8].
- R4: `exc_line[c]` is high exactly when the pending priority of context c is strictly less than its threshold. It is updated on the same edge as the state that feeds it, so an equal value keeps the line low.
- R5: Bit 7 of the status byte (select 3) is set in every cycle in which the comparison of R4 is true. It stays set, even if the threshold is later raised, until an acknowledge clears it.
- R6: Every read returns its data on `rsp_data` with `rsp_valid` high one cycle after the request. An acknowledge (select 0) returns {16'h0, status byte, pending priority} as they were before the acknowledge.
- R7: An acknowledge with a non-empty bitmap clears the bit of the pending priority and loads the threshold with that priority. An empty acknowledge leaves the threshold unchanged. Both clear status bit 7.
- R8: A write to select 1 loads the threshold from `req_wdata`. The line reflects the new threshold after that edge.
- R9: Address bits [5:4] choose the page. Page 0 uses bits [3:2] as the context, and pages 1, 2 and 3 select contexts 0, 1 and 2 whatever bits [3:2] hold. Bits [1:0] are the register select.
- R10: Writes to selects 0, 2 and 3 have no effect on any state.
- R11: When a notification and an acknowledge hit the same context and the same priority in one cycle, the pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ntf_valid | input | 1 | Notification strobe from the router |
| ntf_ctx | input | 2 | Target context of the notification |
| ntf_prio | input | $clog2(NUM_PRIO) | Priority of the notification |
| req_valid | input | 1 | Register access strobe |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 6 | Page, context field and register select |
| req_wdata | input | 8 | Write data (threshold) |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| exc_line | output | 4 | Exception line per context |

## Verification
The bench builds the block with the default of eight priority levels, so a three-bit priority field reaches both ends of the bitmap. Priority 0 is the top level, blocked only by a zero threshold, and priority 7 sits next to the 0xFF "none pending" code. Directed steps cover the boundaries: equal-priority blocking, empty acknowledge, sticky status, the fixed pages ignoring the context field, and a notification colliding with an acknowledge. A long stretch of random traffic is compared cycle by cycle against a behavioural model. That traffic reaches acknowledge, write and notification orderings the directed steps do not list.

// File: rtl/tip_pkg.sv
package tip_pkg;
  localparam int NUM_CTX = 4;
  localparam int PRIO_W  = 8;
  localparam logic [PRIO_W-1:0] PRIO_NONE = 8'hFF;
  localparam int STAT_FLAG_BIT = 7;

  typedef enum logic [1:0] {
    SEL_ACK  = 2'd0,
    SEL_CPPR = 2'd1,
    SEL_STAT = 2'd2,
    SEL_NSR  = 2'd3
  } tip_sel_e;
endpackage

// File: rtl/tip_lowest.sv
module tip_lowest #(
  parameter int N = 8
) (
  input  logic [N-1:0] vec,
  output logic [7:0]   idx
);
  always_comb begin
    idx = 8'hFF;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = 8'(i);
    end
  end
endmodule

// File: rtl/tip_view_dec.sv
module tip_view_dec
  import tip_pkg::*;
(
  input  logic [5:0] addr,
  output logic [1:0] ctx,
  output tip_sel_e   sel
);
  logic [1:0] page;

  always_comb begin
    page = addr[5:4];
    if (page == 2'd0) ctx = addr[3:2];
    else              ctx = page - 2'd1;
    sel = tip_sel_e'(addr[1:0]);
  end
endmodule

// File: rtl/tip_ctx.sv
module tip_ctx
  import tip_pkg::*;
#(
  parameter int NUM_PRIO = 8,
  localparam int PW = $clog2(NUM_PRIO)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ntf_set,
  input  logic [PW-1:0]       ntf_prio,
  input  logic                ack,
  input  logic                thr_wr,
  input  logic [PRIO_W-1:0]   thr_wdata,
  output logic [NUM_PRIO-1:0] pend,
  output logic [PRIO_W-1:0]   best,
  output logic [PRIO_W-1:0]   thr,
  output logic                flag,
  output logic                line
);
  logic [NUM_PRIO-1:0] pend_n, clr_mask, set_mask;
  logic [PRIO_W-1:0]   best_n, thr_n;
  logic                flag_n, line_n, upd;

  tip_lowest #(.N(NUM_PRIO)) u_low (.vec(pend_n), .idx(best_n));

  always_comb begin
    clr_mask = '0;
    set_mask = '0;
    if (ack && best != PRIO_NONE) clr_mask = NUM_PRIO'(1) << best[PW-1:0];
    if (ntf_set)                  set_mask = NUM_PRIO'(1) << ntf_prio;
    pend_n = (pend & ~clr_mask) | set_mask;

    thr_n = thr;
    if (ack && best != PRIO_NONE) thr_n = best;
    else if (thr_wr)              thr_n = thr_wdata;

    line_n = best_n < thr_n;
    flag_n = (flag & ~ack) | line_n;
    upd    = ntf_set | ack | thr_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      best <= PRIO_NONE;
      thr  <= '0;
      flag <= 1'b0;
      line <= 1'b0;
    end else if (upd) begin
      pend <= pend_n;
      best <= best_n;
      thr  <= thr_n;
      flag <= flag_n;
      line <= line_n;
    end
  end
endmodule

// File: rtl/tip_presenter.sv
module tip_presenter
  import tip_pkg::*;
#(
  parameter int NUM_PRIO = 8,
  localparam int PW = $clog2(NUM_PRIO)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ntf_valid,
  input  logic [1:0]    ntf_ctx,
  input  logic [PW-1:0] ntf_prio,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [5:0]    req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_data,
  output logic [3:0]    exc_line
);
  logic [1:0] dec_ctx;
  tip_sel_e   dec_sel;

  logic [NUM_CTX-1:0][NUM_PRIO-1:0] pend_all;
  logic [NUM_CTX-1:0][PRIO_W-1:0]   best_all, thr_all;
  logic [NUM_CTX-1:0]               flag_all, line_all;

  logic        rd_req;
  logic [31:0] rdata_n;

  tip_view_dec u_dec (.addr(req_addr), .ctx(dec_ctx), .sel(dec_sel));

  assign rd_req = req_valid & ~req_write;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    logic hit;
    assign hit = req_valid && (dec_ctx == 2'(c));
    tip_ctx #(.NUM_PRIO(NUM_PRIO)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_n),
      .ntf_set  (ntf_valid && (ntf_ctx == 2'(c))),
      .ntf_prio (ntf_prio),
      .ack      (hit && !req_write && dec_sel == SEL_ACK),
      .thr_wr   (hit && req_write && dec_sel == SEL_CPPR),
      .thr_wdata(req_wdata),
      .pend     (pend_all[c]),
      .best     (best_all[c]),
      .thr      (thr_all[c]),
      .flag     (flag_all[c]),
      .line     (line_all[c])
    );
  end

  assign exc_line = line_all;

  always_comb begin
    logic [7:0] stat;
    stat = 8'(flag_all[dec_ctx]) << STAT_FLAG_BIT;
    unique case (dec_sel)
      SEL_ACK:  rdata_n = {16'h0, stat, best_all[dec_ctx]};
      SEL_CPPR: rdata_n = {24'h0, thr_all[dec_ctx]};
      SEL_STAT: rdata_n = {24'(pend_all[dec_ctx]), best_all[dec_ctx]};
      SEL_NSR:  rdata_n = {24'h0, stat};
      default:  rdata_n = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_data <= rdata_n;
      else        rsp_data <= '0;
    end
  end
endmodule

// File: rtl/tip_presenter_chk.sv
module tip_presenter_chk
  import tip_pkg::*;
#(
  parameter int NUM_PRIO = 8,
  localparam int PW = $clog2(NUM_PRIO)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              ntf_valid,
  input logic [1:0]                        ntf_ctx,
  input logic [PW-1:0]                     ntf_prio,
  input logic                              req_valid,
  input logic                              req_write,
  input logic                              rsp_valid,
  input logic [3:0]                        exc_line,
  input logic [NUM_CTX-1:0][NUM_PRIO-1:0]  pend_all,
  input logic [NUM_CTX-1:0][PRIO_W-1:0]    best_all,
  input logic [NUM_CTX-1:0][PRIO_W-1:0]    thr_all,
  input logic [NUM_CTX-1:0]                flag_all
);
  // R2
  ntf_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ntf_valid) |-> pend_all[$past(ntf_ctx)][$past(ntf_prio)]);

  // R6
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
    // R4
    line_matches_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_line[c] == (best_all[c] < thr_all[c]));
    // R3
    empty_means_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_all[c] == '0) == (best_all[c] == PRIO_NONE));
    // R5
    line_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_line[c] |-> flag_all[c]);
    // R8
    thr_moves_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(thr_all[c]) |-> $past(req_valid));
  end
endmodule

bind tip_presenter tip_presenter_chk #(.NUM_PRIO(NUM_PRIO)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ntf_valid(ntf_valid),
  .ntf_ctx  (ntf_ctx),
  .ntf_prio (ntf_prio),
  .req_valid(req_valid),
  .req_write(req_write),
  .rsp_valid(rsp_valid),
  .exc_line (exc_line),
  .pend_all (pend_all),
  .best_all (best_all),
  .thr_all  (thr_all),
  .flag_all (flag_all)
);

// File: tb/tip_presenter_test.sv
`timescale 1ns/1ps
module tip_presenter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ntf_valid;
  logic [1:0]  ntf_ctx;
  logic [2:0]  ntf_prio;
  logic        req_valid;
  logic        req_write;
  logic [5:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [3:0]  exc_line;

  int total = 0;
  int fails = 0;
  string cur_tag = "R6";

  always #10 clk = ~clk;

  tip_presenter #(.NUM_PRIO(8)) uut (
    .clk(clk), .rst_n(rst_n),
    .ntf_valid(ntf_valid), .ntf_ctx(ntf_ctx), .ntf_prio(ntf_prio),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .exc_line(exc_line)
  );

  // behavioural model
  int  m_pend [4];
  int  m_thr  [4];
  bit  m_flag [4];
  bit  m_line [4];
  bit  e_rv;
  logic [31:0] e_rd;
  int  mc, ms, mp;

  function automatic int lowest(int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 255;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        m_pend[k] = 0; m_thr[k] = 0; m_flag[k] = 0; m_line[k] = 0;
      end
      e_rv = 0; e_rd = 0;
    end else begin
      e_rv = 0; e_rd = 0;
      if (req_valid) begin
        mc = (req_addr[5:4] == 0) ? int'(req_addr[3:2]) : int'(req_addr[5:4]) - 1;
        ms = int'(req_addr[1:0]);
        mp = lowest(m_pend[mc]);
        if (!req_write) begin
          e_rv = 1;
          case (ms)
            0: e_rd = {16'h0, m_flag[mc], 7'h0, 8'(mp)};
            1: e_rd = {24'h0, 8'(m_thr[mc])};
            2: e_rd = {24'(m_pend[mc]), 8'(mp)};
            default: e_rd = {24'h0, m_flag[mc], 7'h0};
          endcase
          if (ms == 0) begin
            if (mp != 255) begin
              m_pend[mc] = m_pend[mc] & ~(1 << mp);
              m_thr[mc]  = mp;
            end
            m_flag[mc] = 0;
          end
        end else if (ms == 1) begin
          m_thr[mc] = int'(req_wdata);
        end
      end
      if (ntf_valid) m_pend[ntf_ctx] = m_pend[ntf_ctx] | (1 << ntf_prio);
      for (int k = 0; k < 4; k++) begin
        m_line[k] = lowest(m_pend[k]) < m_thr[k];
        m_flag[k] = m_flag[k] | m_line[k];
      end
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 line", 32'(exc_line),
          32'({m_line[3], m_line[2], m_line[1], m_line[0]}));
      chk({cur_tag, " rsp_valid"}, 32'(rsp_valid), 32'(e_rv));
      if (e_rv) chk({cur_tag, " rsp_data"}, rsp_data, e_rd);
    end
  end

  function automatic logic [5:0] ad(int page, int ctx, int sel);
    return {2'(page), 2'(ctx), 2'(sel)};
  endfunction

  task automatic notify(int c, int p);
    @(negedge clk);
    ntf_valid = 1; ntf_ctx = 2'(c); ntf_prio = 3'(p);
    @(negedge clk);
    ntf_valid = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    cur_tag = tag;
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk(tag, rsp_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 0; ntf_valid = 0; ntf_ctx = 0; ntf_prio = 0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 lines", 32'(exc_line), 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(ad(0, c, 2), 32'h000000FF, "R1 status");
      rd(ad(0, c, 1), 32'h00000000, "R1 threshold");
      rd(ad(0, c, 3), 32'h00000000, "R1 flag");
    end

    // R2 / R3: notify OS at priority 3, threshold 0 blocks
    notify(1, 3);
    chk("R4 zero threshold blocks", 32'(exc_line), 32'h0);
    rd(ad(2, 0, 2), 32'h00000803, "R2 R3 os status");
    rd(ad(0, 0, 2), 32'h000000FF, "R2 other ctx untouched");

    // R4 / R8: equal threshold keeps line low, higher raises it
    wr(ad(2, 0, 1), 8'd3);
    chk("R4 equal keeps low", 32'(exc_line), 32'h0);
    wr(ad(2, 0, 1), 8'd4);
    chk("R8 line raised", 32'(exc_line), 32'h2);
    rd(ad(2, 0, 3), 32'h00000080, "R5 flag set");
    wr(ad(2, 0, 1), 8'd0);
    chk("R8 line dropped", 32'(exc_line), 32'h0);
    rd(ad(2, 0, 3), 32'h00000080, "R5 flag sticky");
    wr(ad(2, 0, 1), 8'hFF);

    // R3 lowest set bit wins
    notify(1, 5);
    notify(1, 1);
    rd(ad(2, 0, 2), 32'h00002A01, "R3 lowest index");

    // R6 / R7 acknowledge
    rd(ad(2, 0, 0), 32'h00008001, "R6 ack data");
    rd(ad(2, 0, 1), 32'h00000001, "R7 threshold takes ack prio");
    rd(ad(2, 0, 2), 32'h00002803, "R7 bit retired");
    rd(ad(2, 0, 3), 32'h00000000, "R7 flag cleared");
    chk("R7 line after ack", 32'(exc_line), 32'h0);

    // R7 empty acknowledge keeps threshold
    wr(ad(0, 3, 1), 8'h10);
    rd(ad(0, 3, 0), 32'h000000FF, "R7 empty ack data");
    rd(ad(0, 3, 1), 32'h00000010, "R7 empty ack threshold");

    // R9 fixed pages ignore context field
    wr(ad(1, 3, 1), 8'h20);
    rd(ad(0, 0, 1), 32'h00000020, "R9 page1 to hyp");
    rd(ad(0, 3, 1), 32'h00000010, "R9 doorbell untouched");
    notify(2, 6);
    rd(ad(3, 1, 2), 32'h00004006, "R9 page3 to user");

    // R10 writes to read-only selects
    wr(ad(2, 0, 0), 8'h55);
    wr(ad(2, 0, 2), 8'h55);
    wr(ad(2, 0, 3), 8'h55);
    rd(ad(2, 0, 2), 32'h00002803, "R10 status unchanged");
    rd(ad(2, 0, 1), 32'h00000001, "R10 threshold unchanged");

    // R11 notify collides with acknowledge
    wr(ad(3, 0, 1), 8'hFF);
    chk("R4 user line up", 32'(exc_line), 32'h4);
    @(negedge clk);
    cur_tag = "R11 ack data";
    req_valid = 1; req_write = 0; req_addr = ad(3, 0, 0);
    ntf_valid = 1; ntf_ctx = 2; ntf_prio = 6;
    @(negedge clk);
    req_valid = 0; ntf_valid = 0;
    chk("R11 ack data", rsp_data, 32'h00008006);
    rd(ad(3, 0, 2), 32'h00004006, "R11 bit survives");
    rd(ad(3, 0, 1), 32'h00000006, "R11 threshold");
    chk("R11 line", 32'(exc_line), 32'h0);

    // random traffic against the model
    cur_tag = "R6 random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      ntf_valid = ($urandom % 3) == 0;
      ntf_ctx   = 2'($urandom);
      ntf_prio  = 3'($urandom);
      req_valid = ($urandom % 2) == 0;
      req_write = ($urandom % 3) == 0;
      req_addr  = 6'($urandom);
      req_wdata = 8'($urandom % 10);
    end
    @(negedge clk);
    ntf_valid = 0; req_valid = 0;
    repeat (2) @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule